// File: doc/BRIEF.md
# Stop Mode Clock Wake Controller

This block sequences a small clock system into and out of a low-power stop state. Software writes a one to the stop control bit while the system runs. On the next clock edge the block drops the main oscillator enable, the PLL enable and the CPU clock enable. If the peripheral outputs had already been disabled when the stop bit was written, it also asks the pad logic to float the shared pins.

The block leaves stop on either a wake request or an external reset request. It then turns the oscillator and the PLL back on together, and one shared counter times both settling periods. A two-bit select field, sampled in the release cycle, sets the length of that wait to 2^10, 2^12, 2^13 or 2^15 cycles.

The PLL may have been running when stop was entered. In that case only the two longer settings are allowed. A shorter code is replaced by the 2^13 length, and a sticky error flag is raised. After the wait, a wake release hands the clock straight back to the CPU. A reset release first runs a short reset-sequence phase and then hands the clock back. The analog oscillator, the PLL and the pads are outside the block and appear only as enable signals.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, the block is running. `cpu_clk_en` and `osc_en` are 1, `pll_en` follows `pll_use`, and `busy`, `pin_hiz`, `rst_seq` and `ws_err` are 0.
- R2: A cycle with `stop_wr`=1 and `stop_wdata`=1 while running enters stop on that edge. From then on `osc_en`, `pll_en` and `cpu_clk_en` are 0 until release. A write with `stop_wdata`=0, or any write made while not running, has no effect.
- R3: `pin_hiz` is 1 during stop exactly when `periph_out_dis` was 1 in the stop-write cycle. It is 0 whenever stop is not active.
- R4: A cycle in stop with `wake_req` or `ext_rst_req` at 1 releases stop on that edge. `osc_en` then goes to 1, and in the same cycle `pll_en` goes to the value `pll_use` had in the stop-write cycle. Both stay on until the block runs again.
- R5: The stabilization wait lasts L cycles after the release edge. L is 1024, 4096, 8192 or 32768 for `ws_sel` = 00, 01, 10 or 11, sampled in the release cycle. On a wake release, `cpu_clk_en` rises on the edge that ends the L-th cycle.
- R6: If `pll_use` was 1 at stop entry and `ws_sel` is 00 or 01 at release, L is 8192 and `ws_err` rises after the release edge. `ws_err` then stays 1 until `rst_n`.
- R7: On a release caused by `ext_rst_req`, `rst_seq` is 1 for RST_SEQ_LEN cycles (default 4) after the wait, with `cpu_clk_en` at 0. `cpu_clk_en` rises when `rst_seq` falls. If `ext_rst_req` and `wake_req` arrive in the same cycle, the reset path is taken.
- R8: During the wait, `wake_req`, `ext_rst_req`, `stop_wr` and changes of `ws_sel` do not change its length. While running, `wake_req` and `ext_rst_req` have no effect.
- R9: `busy` is 1 exactly while stop is active or the wait is running. It is 0 while running and during the reset-sequence phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that also times the wait |
| rst_n | input | 1 | Synchronous active-low block reset |
| stop_wr | input | 1 | Write strobe for the stop control bit |
| stop_wdata | input | 1 | Value written to the stop control bit |
| ws_sel | input | 2 | Wait length select, sampled at release |
| pll_use | input | 1 | PLL is in use as the clock source |
| periph_out_dis | input | 1 | Peripheral outputs on shared pins are disabled |
| wake_req | input | 1 | Wake request that releases stop |
| ext_rst_req | input | 1 | External reset request that releases stop |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| pin_hiz | output | 1 | Request to float the shared pins |
| cpu_clk_en | output | 1 | CPU clock enable |
| rst_seq | output | 1 | Reset sequence phase active |
| busy | output | 1 | Stop or stabilization wait active |
| ws_err | output | 1 | Sticky flag for an illegal wait code on a PLL wake |

## Verification
The controller is compared against the reference model on every cycle. A wrong phase therefore shows up on the enable outputs at the first falling edge after the faulty clock edge. A miscounted wait first appears at the very end of the wait, as a `busy` fall and `cpu_clk_en` rise that come too early or too late. For that reason the busy interval is also measured as a whole against L. A wrong latch of the PLL or pin state shows immediately in `pll_en` or `pin_hiz`. A lost error flag shows the cycle after release and at every cycle after that.

// File: rtl/swc_pkg.sv
// Shared types for the stop mode clock wake controller.
package swc_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2,
        ST_RSEQ = 2'd3
    } swc_state_t;
endpackage

// File: rtl/swc_wait_sel.sv
// Wait length selector.
// Maps the two-bit select code to a cycle count of 2**exponent.
// When the wake follows a stop entered with the PLL running, codes 00 and 01
// are replaced by code 10 and the error output is raised.
// Assumes every exponent is below CW.
module swc_wait_sel #(
    parameter int EXP0 = 10,
    parameter int EXP1 = 12,
    parameter int EXP2 = 13,
    parameter int EXP3 = 15,
    parameter int CW   = 16
) (
    input  logic [1:0]    ws_sel,
    input  logic          pll_stop,
    output logic [CW-1:0] len,
    output logic          force_err
);
    logic [CW-1:0] len_tab [4];
    logic [1:0]    code_eff;

    function automatic int exp_of(input int idx);
        case (idx)
            0:       return EXP0;
            1:       return EXP1;
            2:       return EXP2;
            default: return EXP3;
        endcase
    endfunction

    // Build the length table, one entry per select code.
    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign len_tab[g] = CW'(1) << exp_of(g);
    end

    // Force a legal code on a PLL wake with a short select.
    always_comb begin
        force_err = pll_stop && !ws_sel[1];
        code_eff  = force_err ? 2'b10 : ws_sel;
        len       = len_tab[code_eff];
    end
endmodule

// File: rtl/swc_cnt.sv
// Down counter that runs once per load.
// A load starts a run of load_val cycles. done is high in the last cycle of
// the run. Loads that arrive while a run is active restart it, so the owner
// must issue only one load per run. Assumes load_val >= 1.
module swc_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic          active;

    // Count down from load_val-1 to zero, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= load_val - CW'(1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else            cnt    <= cnt - CW'(1);
        end
    end

    assign done = active && (cnt == '0);
endmodule

// File: rtl/swc_seq_fsm.sv
// Phase sequencer: run, stop, stabilization wait, reset sequence.
// Records whether the release came from an external reset (which wins over
// a wake). Emits one-cycle pulses that start the wait and sequence counters.
module swc_seq_fsm
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_set,
    input  logic       wake_req,
    input  logic       ext_rst_req,
    input  logic       wait_done,
    input  logic       seq_done,
    output swc_state_t state,
    output logic       enter_stop,
    output logic       release_go,
    output logic       seq_go
);
    swc_state_t state_nx;
    logic       cause_ext;

    // Decode the start pulses from the current phase and its inputs.
    always_comb begin
        enter_stop = (state == ST_RUN)  && stop_set;
        release_go = (state == ST_STOP) && (wake_req || ext_rst_req);
        seq_go     = (state == ST_WAIT) && wait_done && cause_ext;
    end

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:  if (stop_set)   state_nx = ST_STOP;
            ST_STOP: if (release_go) state_nx = ST_WAIT;
            ST_WAIT: if (wait_done)  state_nx = cause_ext ? ST_RSEQ : ST_RUN;
            ST_RSEQ: if (seq_done)   state_nx = ST_RUN;
            default:                 state_nx = ST_RUN;
        endcase
    end

    // Phase register and release cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            cause_ext <= 1'b0;
        end else begin
            state <= state_nx;
            if (release_go) cause_ext <= ext_rst_req;
        end
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
// Stop mode clock wake controller (top).
// Enters stop on a write of one to the stop bit and disables the oscillator,
// the PLL and the CPU clock. Releases stop on wake or external reset.
// Restarts the oscillator and PLL together and times one shared
// stabilization wait. An external reset release then runs a reset sequence
// phase. Assumes inputs are synchronous to clk.
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int WS_EXP0     = 10,
    parameter int WS_EXP1     = 12,
    parameter int WS_EXP2     = 13,
    parameter int WS_EXP3     = 15,
    parameter int RST_SEQ_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_wr,
    input  logic       stop_wdata,
    input  logic [1:0] ws_sel,
    input  logic       pll_use,
    input  logic       periph_out_dis,
    input  logic       wake_req,
    input  logic       ext_rst_req,
    output logic       osc_en,
    output logic       pll_en,
    output logic       pin_hiz,
    output logic       cpu_clk_en,
    output logic       rst_seq,
    output logic       busy,
    output logic       ws_err
);
    localparam int MAX01 = (WS_EXP0 > WS_EXP1) ? WS_EXP0 : WS_EXP1;
    localparam int MAX23 = (WS_EXP2 > WS_EXP3) ? WS_EXP2 : WS_EXP3;
    localparam int CW    = ((MAX01 > MAX23) ? MAX01 : MAX23) + 1;
    localparam int SW    = $clog2(RST_SEQ_LEN + 1);
    localparam logic [SW-1:0] SEQ_LEN_V = SW'(RST_SEQ_LEN);

    swc_state_t    state;
    logic          enter_stop, release_go, seq_go;
    logic          wait_done, seq_done;
    logic          pll_stop_q, hiz_q;
    logic [CW-1:0] wait_len;
    logic          force_err;

    swc_seq_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_set    (stop_wr && stop_wdata),
        .wake_req    (wake_req),
        .ext_rst_req (ext_rst_req),
        .wait_done   (wait_done),
        .seq_done    (seq_done),
        .state       (state),
        .enter_stop  (enter_stop),
        .release_go  (release_go),
        .seq_go      (seq_go)
    );

    swc_wait_sel #(
        .EXP0 (WS_EXP0), .EXP1 (WS_EXP1), .EXP2 (WS_EXP2), .EXP3 (WS_EXP3), .CW (CW)
    ) i_sel (
        .ws_sel    (ws_sel),
        .pll_stop  (pll_stop_q),
        .len       (wait_len),
        .force_err (force_err)
    );

    swc_cnt #(.CW (CW)) i_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (release_go),
        .load_val (wait_len),
        .done     (wait_done)
    );

    swc_cnt #(.CW (SW)) i_seq_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_go),
        .load_val (SEQ_LEN_V),
        .done     (seq_done)
    );

    // Capture PLL use and pin-float permission at stop entry; hold the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_stop_q <= 1'b0;
            hiz_q      <= 1'b0;
            ws_err     <= 1'b0;
        end else begin
            if (enter_stop) begin
                pll_stop_q <= pll_use;
                hiz_q      <= periph_out_dis;
            end
            if (release_go && force_err) ws_err <= 1'b1;
        end
    end

    // Output decode from the phase.
    always_comb begin
        osc_en     = (state != ST_STOP);
        pll_en     = (state == ST_RUN) ? pll_use : ((state == ST_STOP) ? 1'b0 : pll_stop_q);
        pin_hiz    = (state == ST_STOP) && hiz_q;
        cpu_clk_en = (state == ST_RUN);
        rst_seq    = (state == ST_RSEQ);
        busy       = (state == ST_STOP) || (state == ST_WAIT);
    end
endmodule

// File: rtl/swc_checker.sv
// Port-level property checker for stop_wake_ctrl, attached by bind.
module swc_checker (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic pll_en,
    input logic pin_hiz,
    input logic cpu_clk_en,
    input logic rst_seq,
    input logic busy,
    input logic ws_err
);
    assert_pll_off_with_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !pll_en);

    assert_hiz_only_in_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz |-> (!osc_en && busy));

    assert_wait_keeps_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && osc_en) |=> osc_en);

    assert_busy_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cpu_clk_en || rst_seq));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ws_err |=> ws_err);

    assert_seq_to_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_seq) |-> cpu_clk_en);

    assert_cpu_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (!busy && !rst_seq));
endmodule

bind stop_wake_ctrl swc_checker i_swc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .pll_en     (pll_en),
    .pin_hiz    (pin_hiz),
    .cpu_clk_en (cpu_clk_en),
    .rst_seq    (rst_seq),
    .busy       (busy),
    .ws_err     (ws_err)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_wr = 1'b0, stop_wdata = 1'b0;
    logic [1:0] ws_sel = 2'b00;
    logic pll_use = 1'b0, periph_out_dis = 1'b0;
    logic wake_req = 1'b0, ext_rst_req = 1'b0;
    logic osc_en, pll_en, pin_hiz, cpu_clk_en, rst_seq, busy, ws_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_wake_ctrl i_stop_wake_ctrl (
        .clk (clk), .rst_n (rst_n), .stop_wr (stop_wr), .stop_wdata (stop_wdata),
        .ws_sel (ws_sel), .pll_use (pll_use), .periph_out_dis (periph_out_dis),
        .wake_req (wake_req), .ext_rst_req (ext_rst_req),
        .osc_en (osc_en), .pll_en (pll_en), .pin_hiz (pin_hiz),
        .cpu_clk_en (cpu_clk_en), .rst_seq (rst_seq), .busy (busy), .ws_err (ws_err)
    );

    // Reference model: 0 run, 1 stop, 2 wait, 3 reset sequence
    int m_mode = 0, m_left = 0;
    bit m_pll = 0, m_hiz = 0, m_err = 0, m_ext = 0;

    function automatic int wait_len(input int code);
        case (code)
            0: return 1024;
            1: return 4096;
            2: return 8192;
            default: return 32768;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0; m_left <= 0; m_pll <= 0; m_hiz <= 0; m_err <= 0; m_ext <= 0;
        end else begin
            case (m_mode)
                0: if (stop_wr && stop_wdata) begin
                       m_mode <= 1; m_pll <= pll_use; m_hiz <= periph_out_dis;
                   end
                1: if (wake_req || ext_rst_req) begin
                       m_mode <= 2;
                       m_ext  <= ext_rst_req;
                       if (m_pll && ws_sel < 2) begin
                           m_err <= 1; m_left <= wait_len(2);
                       end else begin
                           m_left <= wait_len(int'(ws_sel));
                       end
                   end
                2: if (m_left == 1) begin
                       m_mode <= m_ext ? 3 : 0; m_left <= 4;
                   end else m_left <= m_left - 1;
                default: if (m_left == 1) m_mode <= 0; else m_left <= m_left - 1;
            endcase
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check_eq("R2 osc_en",     osc_en,     m_mode != 1);
            check_eq("R4 pll_en",     pll_en,     (m_mode == 0) ? pll_use : (m_mode == 1 ? 0 : m_pll));
            check_eq("R3 pin_hiz",    pin_hiz,    (m_mode == 1) && m_hiz);
            check_eq("R5 cpu_clk_en", cpu_clk_en, m_mode == 0);
            check_eq("R7 rst_seq",    rst_seq,    m_mode == 3);
            check_eq("R9 busy",       busy,       (m_mode == 1) || (m_mode == 2));
            check_eq("R6 ws_err",     ws_err,     m_err);
        end
    end

    task automatic stop_cycle(input logic [1:0] ws, input bit pll, input bit dis,
                              input bit ext, input bit disturb, input int exp_len,
                              input string tag);
        int n;
        @(negedge clk);
        pll_use = pll; periph_out_dis = dis; stop_wr = 1; stop_wdata = 1;
        @(negedge clk);
        stop_wr = 0;
        check_eq("R2 stop entered", busy && !cpu_clk_en && !osc_en, 1);
        check_eq("R3 hiz latch", pin_hiz, dis);
        repeat (3) @(negedge clk);
        ws_sel = ws;
        if (ext) begin ext_rst_req = 1; wake_req = 1; end
        else wake_req = 1;
        @(negedge clk);
        wake_req = 0; ext_rst_req = 0;
        check_eq("R4 restart together", osc_en && (pll_en == pll), 1);
        n = 0;
        while (busy) begin
            n++;
            if (disturb && n == 100) begin
                wake_req = 1; ext_rst_req = 1; stop_wr = 1; ws_sel = 2'b11;
            end else begin
                wake_req = 0; ext_rst_req = 0; stop_wr = 0;
            end
            @(negedge clk);
        end
        wake_req = 0; ext_rst_req = 0; stop_wr = 0;
        check_eq(tag, n, exp_len);
        if (ext) begin
            n = 0;
            while (rst_seq) begin n++; @(negedge clk); end
            check_eq("R7 reset sequence length", n, 4);
        end
        check_eq("R5 cpu clock back", cpu_clk_en, 1);
        ws_sel = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_eq("R1 reset state",
                 {cpu_clk_en, osc_en, pll_en, busy, pin_hiz, rst_seq, ws_err}, 7'b1100000);

        // R8: requests while running are ignored
        wake_req = 1; ext_rst_req = 1;
        @(negedge clk);
        wake_req = 0; ext_rst_req = 0;
        @(negedge clk);
        check_eq("R8 run ignores requests", cpu_clk_en && !rst_seq && !busy, 1);

        // R2: writing zero does nothing
        stop_wr = 1; stop_wdata = 0;
        @(negedge clk);
        stop_wr = 0;
        @(negedge clk);
        check_eq("R2 zero write ignored", cpu_clk_en && osc_en && !busy, 1);

        stop_cycle(2'b00, 0, 0, 0, 0, 1024,  "R5 wait code 00");
        stop_cycle(2'b01, 0, 1, 0, 0, 4096,  "R5 wait code 01");
        stop_cycle(2'b10, 1, 1, 0, 0, 8192,  "R5 wait code 10 pll");
        check_eq("R6 no error on legal code", ws_err, 0);
        stop_cycle(2'b00, 1, 0, 0, 0, 8192,  "R6 forced wait length");
        check_eq("R6 error set", ws_err, 1);
        stop_cycle(2'b11, 0, 0, 1, 0, 32768, "R7 ext reset wait code 11");
        check_eq("R6 error sticky", ws_err, 1);
        stop_cycle(2'b01, 0, 0, 0, 1, 4096,  "R8 wait not disturbed");

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule